// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a byte-wide EEPROM model that answers as a target on a two-wire serial bus. It takes clock and data lines that come from the pins, brings them into the system clock domain, and pulls the data line low through an open-drain enable. This is how it acknowledges and how it returns read data. A host addresses it with a device word, a two-byte memory address and data bytes. It can then store a single byte or a run of bytes within one page. It can also read back from the current address, from an address it loads with a dummy write, or as a stream that runs until the host stops acknowledging.

After a write, a cycle counter stands in for the self-timed programming period. While that counter runs the target does not acknowledge its device word, so the host finds out when the write is done by polling. A configuration parameter halves the array. In that mode the top bit of the memory address has no effect. The array is sized by a parameter. A width of 15 gives the 32K x 8 part, and the default stays small.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, and at any time while idle, the data enable `sda_oe_o` is low (line released).
- R2: A falling data line while the clock is high starts a new device word at any point in a transfer. A rising data line while the clock is high ends the transfer and returns the target to idle.
- R3: The device word is sent MSB first. Bits [7:4] must equal 4'b1010, bits [3:1] must equal parameter `DEV_SEL`, and bit 0 selects read (1) or write (0). On a match the target pulls the line low through the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: A write takes the high address byte, then the low address byte, then data bytes. Address bits above the array width are ignored. Every byte is acknowledged and every data byte is stored.
- R5: For `WR_CYCLES` clocks after a write ends, the device word is not acknowledged. Afterwards it is acknowledged again.
- R6: A write that carries only the two address bytes, followed by a repeated start and a read device word, returns the byte at that address.
- R7: The programming period starts only at a stop that follows at least one data byte. An address-only write leaves the target ready at once.
- R8: During a write, the low 6 address bits wrap inside their 64-byte page, and the upper bits do not change.
- R9: The address counter advances after every byte read or written. A current-address read returns the byte after the last one accessed.
- R10: A read keeps sending bytes while the host acknowledges them and ends at a host no-acknowledge. The address after the last location rolls over to 0.
- R11: With `HALF_SIZE`=1 the top bit of the `MEM_AW`-bit address is ignored, so two addresses that differ only in that bit select the same byte.
- R12: The target changes `sda_oe_o` only while the clock is low. Read data goes out MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line from the pin |
| sda_i | input | 1 | Bus data line from the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench puts a full-size target and a half-size target on one bus and drives them as a host would. The first corner case is polling right after a write. A target that ignored its busy period would acknowledge the first poll, and one that never left it would exhaust the poll limit. The second is a page write that crosses a page boundary. A counter that carried into the upper bits would write into the next page, and the bench checks a byte placed there earlier. The third is a streamed read from the last address and a half-size access through the top address bit. A counter that failed to roll over, or a decoder that kept the top bit, would return a different byte than the one written.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } fsm_e;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_AHI,
    BY_ALO,
    BY_DATA
  } byte_e;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_q;
  logic sda_m, sda_s, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  assign scl_o   = scl_s;
  assign sda_o   = sda_s;
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
  // data edge while clock held high
  assign start_o = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import serial_mem_pkg::*;
#(
  parameter int unsigned MEM_AW    = 10,
  parameter bit          HALF_SIZE = 1'b0,
  parameter logic [3:0]  DEV_CODE  = 4'b1010,
  parameter logic [2:0]  DEV_SEL   = 3'b000,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  // effective array width, must stay within 9..16
  localparam int unsigned AW = HALF_SIZE ? MEM_AW - 1 : MEM_AW;
  localparam int unsigned HW = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, wr_trig;
  logic [7:0] rdata;

  fsm_e          state;
  byte_e         kind;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          ack_on;
  logic          rw_q;
  logic          wr_pend;
  logic [AW-1:0] addr_q;
  logic [HW-1:0] ahi_q;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [7:0]    mem_wd;

  logic [7:0] rx_byte;
  logic       dev_match;

  bus_sampler u_sampler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall),
    .start_o (start_det),
    .stop_o  (stop_det)
  );

  write_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (wr_trig),
    .busy_o (busy)
  );

  byte_array #(.AW(AW)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_wa),
    .wdata_i (mem_wd),
    .raddr_i (addr_q),
    .rdata_o (rdata)
  );

  assign rx_byte   = {shreg[6:0], sda_s};
  assign dev_match = (rx_byte[7:1] == {DEV_CODE, DEV_SEL}) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      kind    <= BY_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      ack_on  <= 1'b0;
      rw_q    <= 1'b0;
      wr_pend <= 1'b0;
      addr_q  <= '0;
      ahi_q   <= '0;
      mem_we  <= 1'b0;
      mem_wa  <= '0;
      mem_wd  <= '0;
      wr_trig <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      wr_trig <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= BY_DEV;
        bit_cnt <= '0;
        ack_on  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        ack_on  <= 1'b0;
        wr_trig <= wr_pend;
        wr_pend <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= rx_byte;
            if (bit_cnt == 4'd7) begin
              bit_cnt <= '0;
              ack_on  <= 1'b0;
              state   <= ST_ACK;
              case (kind)
                BY_DEV: begin
                  rw_q <= rx_byte[0];
                  if (!dev_match) state <= ST_IDLE;
                end
                BY_AHI: ahi_q <= rx_byte[HW-1:0];
                BY_ALO: addr_q <= {ahi_q, rx_byte};
                default: begin
                  mem_we  <= 1'b1;
                  mem_wa  <= addr_q;
                  mem_wd  <= rx_byte;
                  wr_pend <= 1'b1;
                  addr_q  <= {addr_q[AW-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                end
              endcase
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              state  <= ST_RX;
              case (kind)
                BY_DEV: begin
                  if (rw_q) begin
                    state   <= ST_TX;
                    shreg   <= rdata;
                    addr_q  <= addr_q + AW'(1);
                    bit_cnt <= '0;
                  end else begin
                    kind <= BY_AHI;
                  end
                end
                BY_AHI: kind <= BY_ALO;
                BY_ALO: kind <= BY_DATA;
                default: kind <= BY_DATA;
              endcase
            end
          end
          ST_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                state  <= ST_RACK;
                ack_on <= 1'b0;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (!sda_s) ack_on <= 1'b1;
              else        state  <= ST_IDLE;
            end
            if (scl_fall && ack_on) begin
              ack_on  <= 1'b0;
              state   <= ST_TX;
              shreg   <= rdata;
              addr_q  <= addr_q + AW'(1);
              bit_cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = ((state == ST_ACK) && ack_on) || ((state == ST_TX) && !shreg[7]);
endmodule

// File: rtl/serial_mem_target_chk.sv
module serial_mem_target_chk
  import serial_mem_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned PW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          busy,
  input logic          sda_oe_o,
  input fsm_e          state,
  input logic [3:0]    bit_cnt,
  input logic          mem_we,
  input logic [AW-1:0] addr_q
);
  assert_oe_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);

  assert_start_enters_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == ST_RX && bit_cnt == 4'd0));

  assert_busy_no_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  assert_cycle_after_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det, 2));

  assert_page_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])));

  assert_drive_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind serial_mem_target serial_mem_target_chk #(.AW(AW), .PW(PAGE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy      (busy),
  .sda_oe_o  (sda_oe_o),
  .state     (state),
  .bit_cnt   (bit_cnt),
  .mem_we    (mem_we),
  .addr_q    (addr_q)
);

// File: tb/serial_mem_target_test.sv
module serial_mem_target_test;
  localparam int unsigned WR = 300;
  localparam logic [7:0] FW = 8'hA0, FR = 8'hA1, HWR = 8'hA2, HRD = 8'hA3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic oe_a, oe_b, sda_line;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] rb [4];

  always #4 clk = ~clk;
  assign sda_line = ~(host_low | oe_a | oe_b);

  serial_mem_target #(.MEM_AW(10), .HALF_SIZE(1'b0), .DEV_SEL(3'b000), .WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe_a));

  serial_mem_target #(.MEM_AW(10), .HALF_SIZE(1'b1), .DEV_SEL(3'b001), .WR_CYCLES(WR)) uut_half (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(oe_b));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; q(); scl = 1'b1; q(); host_low = 1'b1; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; q(); scl = 1'b1; q(); host_low = 1'b0; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    host_low = 1'b0; q(); scl = 1'b1; q();
    ack = ~sda_line;
    q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      q(); scl = 1'b1; q(); b = {b[6:0], sda_line}; q(); scl = 1'b0;
    end
    q(); host_low = give_ack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    host_low = 1'b0;
  endtask

  task automatic poll_ready(input logic [7:0] dw, output int tries);
    logic a;
    tries = 0;
    do begin
      tries++;
      bus_start(); send_byte(dw, a); bus_stop();
    end while (!a && tries < 60);
  endtask

  task automatic write_run(input logic [7:0] dw, input logic [15:0] adr, input int n,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3);
    logic a;
    logic [7:0] d [4];
    int t;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    bus_start();
    send_byte(dw, a);        check("R3 device word ack", a, 1);
    send_byte(adr[15:8], a); check("R4 high address ack", a, 1);
    send_byte(adr[7:0], a);  check("R4 low address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);    check("R4 data ack", a, 1);
    end
    bus_stop();
    poll_ready(dw, t);
  endtask

  task automatic read_run(input logic [7:0] dw, input logic [15:0] adr, input int n);
    logic a;
    bus_start();
    send_byte(dw, a);
    send_byte(adr[15:8], a);
    send_byte(adr[7:0], a);
    bus_start();
    send_byte(dw | 8'h01, a); check("R6 read word ack", a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R1 full target released after reset", oe_a, 0);
    check("R1 half target released after reset", oe_b, 0);
  endtask

  task automatic t_byte_write_random_read();
    write_run(FW, 16'h0123, 1, 8'hA5, 0, 0, 0);
    read_run(FW, 16'h0123, 1);
    check("R6 R12 random read data", rb[0], 8'hA5);
  endtask

  task automatic t_busy_poll();
    logic a;
    int t;
    bus_start(); send_byte(FW, a); send_byte(8'h00, a); send_byte(8'h40, a);
    send_byte(8'h77, a); bus_stop();
    bus_start(); send_byte(FW, a); bus_stop();
    check("R5 no ack right after write", a, 0);
    poll_ready(FW, t);
    check("R5 ack returns after cycle", (t > 0 && t < 60) ? 1 : 0, 1);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start(); send_byte(8'hB0, a); bus_stop();
    check("R3 wrong code no ack", a, 0);
    bus_start(); send_byte(8'hA4, a); bus_stop();
    check("R3 wrong select no ack", a, 0);
    bus_start(); send_byte(8'hB0, a); send_byte(FW, a);
    check("R3 bytes after mismatch ignored", a, 0);
    bus_start(); send_byte(FW, a); bus_stop();
    check("R2 R3 new start recovers", a, 1);
  endtask

  task automatic t_no_data_no_cycle();
    logic a;
    bus_start(); send_byte(FW, a); send_byte(8'h00, a); send_byte(8'h10, a); bus_stop();
    bus_start(); send_byte(FW, a); bus_stop();
    check("R7 address-only write leaves target ready", a, 1);
  endtask

  task automatic t_page_wrap();
    write_run(FW, 16'h003E, 4, 8'h11, 8'h22, 8'h33, 8'h44);
    read_run(FW, 16'h003E, 2);
    check("R8 page byte 62", rb[0], 8'h11);
    check("R8 page byte 63", rb[1], 8'h22);
    read_run(FW, 16'h0000, 2);
    check("R8 wrapped to page start", rb[0], 8'h33);
    check("R8 wrapped second byte", rb[1], 8'h44);
    read_run(FW, 16'h0040, 1);
    check("R8 next page untouched", rb[0], 8'h77);
  endtask

  task automatic t_current();
    logic a;
    logic [7:0] b;
    write_run(FW, 16'h0100, 3, 8'h01, 8'h02, 8'h03, 0);
    read_run(FW, 16'h0100, 1);
    check("R9 first byte", rb[0], 8'h01);
    bus_start(); send_byte(FR, a); recv_byte(1'b0, b); bus_stop();
    check("R9 current-address read", b, 8'h02);
    bus_start(); send_byte(FR, a); recv_byte(1'b0, b); bus_stop();
    check("R9 counter advanced again", b, 8'h03);
  endtask

  task automatic t_seq_rollover();
    write_run(FW, 16'h03FF, 1, 8'h5C, 0, 0, 0);
    read_run(FW, 16'h03FF, 3);
    check("R10 last address", rb[0], 8'h5C);
    check("R10 rollover to 0", rb[1], 8'h33);
    check("R10 stream continues", rb[2], 8'h44);
  endtask

  task automatic t_half();
    write_run(FW, 16'h0205, 1, 8'h9E, 0, 0, 0);
    write_run(FW, 16'h0005, 1, 8'h12, 0, 0, 0);
    write_run(HWR, 16'h0205, 1, 8'h6B, 0, 0, 0);
    read_run(HWR, 16'h0005, 1);
    check("R11 half size ignores top bit", rb[0], 8'h6B);
    read_run(FW, 16'h0005, 1);
    check("R11 full size low alias", rb[0], 8'h12);
    read_run(FW, 16'h0205, 1);
    check("R11 full size keeps top bit", rb[0], 8'h9E);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write_random_read();
    t_busy_poll();
    t_mismatch();
    t_no_data_no_cycle();
    t_page_wrap();
    t_current();
    t_seq_rollover();
    t_half();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule